// File: doc/BRIEF.md
# MLT-3 Transmit Serializer Path

This block is the digital transmit side of a 100 Mb/s twisted-pair line interface. It runs on the fast bit clock. Once per symbol period, the upstream coding logic presents a 5-bit code group with a one-cycle load strobe. The block shifts each group out one bit per clock, least significant bit first. It turns the serial NRZ stream into NRZI, then maps the NRZI transitions onto the three-level MLT-3 line code. The result is a signed 2-bit line level for the analog wave-shaping driver.

Three control inputs change the normal flow:
- **Auto-negotiation pass-through.** The top bit of the code-group input drives link pulses straight onto the line, and the encoder is bypassed.
- **Transmit disable.** The line is held at zero at once, and all encoder and serializer state is cleared.
- **Loopback.** The serial NRZ bit is sent to a tap for the receive side, and the line is kept quiet.

Top module: `mlt3_tx_path`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `line_lvl` is 2'b00 and `lb_bit` is 0.
- R2: A group on `tx_word` is captured at the clock edge where `word_stb` is high. Bit i of the group (bit 0 first) feeds the line encoder at the (i+1)-th edge after capture. With no new strobe, zeros are shifted in. A strobe that arrives during a group replaces the remaining bits.
- R3: NRZI conversion: each serial 1 makes a transition and each serial 0 makes none. Each transition moves the MLT-3 level one step, visible after the consuming edge.
- R4: The level steps through the cycle zero, +1, zero, -1, zero, and so on. The encodings are 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. The output never shows 2'b10 and never goes directly between +1 and -1.
- R5: A serial 0 leaves the line level unchanged, including while idle zeros shift in.
- R6: While `autoneg_en` is high (and `tx_disable` is low), `line_lvl` is 2'b01 when `tx_word[4]` was 1 at the previous clock edge, and 2'b00 otherwise. The MLT-3 encoder is held at level zero.
- R7: While `tx_disable` is high, `line_lvl` is 2'b00 in the same cycle, and the serializer and encoder are cleared. After release, the first serial 1 gives +1.
- R8: While `loopback_en` is high and `tx_disable` is low, `lb_bit` equals the current serial NRZ bit, `line_lvl` is 2'b00 and the encoder is held at zero. Otherwise `lb_bit` is 0.
- R9: Priority is transmit disable, then auto-negotiation, then loopback, then normal MLT-3 output.
- R10: Strobes spaced exactly five clocks apart give a continuous serial stream with no gap or repeated bit between groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock (one serial bit per cycle) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_stb | input | 1 | Load strobe for the code group on `tx_word` |
| tx_word | input | 5 | Parallel code group; bit 4 carries link pulses in pass-through mode |
| autoneg_en | input | 1 | Auto-negotiation pass-through select |
| tx_disable | input | 1 | Forces a quiet line and clears state |
| loopback_en | input | 1 | Routes the serial stream to `lb_bit` and quiets the line |
| line_lvl | output | 2 | Line level: 00 zero, 01 plus one, 11 minus one |
| lb_bit | output | 1 | Serial NRZ loopback tap |

## Verification
The encoder is tested with these groups:
- **All ones.** This walks the full four-step MLT-3 cycle and shows whether the step direction and the zero crossings are right.
- **A single 1 in bit 1.** This separates LSB-first from MSB-first order and confirms that the trailing zeros hold the level.
- **A long pseudo-random sequence at the exact five-clock strobe spacing.** This catches gaps or duplicated bits at group boundaries.
- **A strobe in the middle of a group.** This shows whether the remaining bits are replaced.

For the control inputs:
- **Link-pulse patterns on bit 4** tell pass-through apart from the encoded path.
- **Loopback groups** show that the tap carries NRZ rather than NRZI.
- **Overlapping controls** settle the priority order.

// File: rtl/mlt3_tx_pkg.sv
package mlt3_tx_pkg;

  typedef logic [1:0] line_lvl_t;

  localparam line_lvl_t LVL_ZERO = 2'b00;
  localparam line_lvl_t LVL_POS  = 2'b01;
  localparam line_lvl_t LVL_NEG  = 2'b11;

  // position within the four-step MLT-3 cycle
  typedef enum logic [1:0] {
    PH_ZERO_RISE = 2'd0,
    PH_POS       = 2'd1,
    PH_ZERO_FALL = 2'd2,
    PH_NEG       = 2'd3
  } mlt_phase_t;

  function automatic line_lvl_t phase_to_lvl(input mlt_phase_t ph);
    line_lvl_t lvl;
    case (ph)
      PH_POS:  lvl = LVL_POS;
      PH_NEG:  lvl = LVL_NEG;
      default: lvl = LVL_ZERO;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SYM_W-1:0] word,
  output logic             bit_o
);

  logic [SYM_W-1:0] shift_q;
  logic [SYM_W-1:0] shift_d;

  // next state: clear wins, then load, else shift toward bit 0
  always_comb begin
    if (clr) begin
      shift_d = '0;
    end else if (load) begin
      shift_d = word;
    end else begin
      shift_d = {1'b0, shift_q[SYM_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign bit_o = shift_q[0];

  AST_SER_LSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (bit_o == $past(word[0]))); // R2

  AST_SER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !bit_o); // R7

endmodule

// File: rtl/nrzi_mlt3_enc.sv
module nrzi_mlt3_enc
  import mlt3_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      bit_in,
  output line_lvl_t level_o
);

  logic       nrzi_q;
  logic       nrzi_d;
  logic       nrzi_edge;
  mlt_phase_t phase_q;
  mlt_phase_t phase_d;

  // NRZ to NRZI, then each NRZI transition advances the MLT-3 phase
  always_comb begin
    if (clr) begin
      nrzi_d = 1'b0;
    end else begin
      nrzi_d = nrzi_q ^ bit_in;
    end
    nrzi_edge = !clr && (nrzi_d != nrzi_q);
    if (clr) begin
      phase_d = PH_ZERO_RISE;
    end else if (nrzi_edge) begin
      phase_d = mlt_phase_t'(phase_q + 2'd1);
    end else begin
      phase_d = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrzi_q  <= 1'b0;
      phase_q <= PH_ZERO_RISE;
    end else begin
      nrzi_q  <= nrzi_d;
      phase_q <= phase_d;
    end
  end

  assign level_o = phase_to_lvl(phase_q);

  AST_MLT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && bit_in) |=> (level_o != $past(level_o))); // R3

  AST_MLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !bit_in) |=> $stable(level_o)); // R5

  AST_MLT_NO_POS_TO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == LVL_POS) |=> (level_o != LVL_NEG)); // R4

  AST_MLT_NO_NEG_TO_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == LVL_NEG) |=> (level_o != LVL_POS)); // R4

  AST_MLT_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (level_o == LVL_ZERO)); // R7

endmodule

// File: rtl/tx_line_sel.sv
module tx_line_sel
  import mlt3_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dis,
  input  logic      an,
  input  logic      lb,
  input  logic      flp_in,
  input  logic      ser_bit,
  input  line_lvl_t mlt_lvl,
  output line_lvl_t line_o,
  output logic      lb_bit_o,
  output logic      ser_clr_o,
  output logic      enc_clr_o
);

  logic flp_q;

  // link pulse bit is registered once before reaching the line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flp_q <= 1'b0;
    end else begin
      flp_q <= flp_in;
    end
  end

  always_comb begin
    ser_clr_o = dis;
    enc_clr_o = dis || an || lb;
    lb_bit_o  = lb && !dis && ser_bit;
    if (dis) begin
      line_o = LVL_ZERO;
    end else if (an) begin
      line_o = flp_q ? LVL_POS : LVL_ZERO;
    end else if (lb) begin
      line_o = LVL_ZERO;
    end else begin
      line_o = mlt_lvl;
    end
  end

  AST_FLP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (an && !dis && $past(rst_n)) |->
      (line_o == ($past(flp_in) ? LVL_POS : LVL_ZERO))); // R6

  AST_LINE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    line_o != 2'b10); // R4

endmodule

// File: rtl/mlt3_tx_path.sv
module mlt3_tx_path
  import mlt3_tx_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_stb,
  input  logic [SYM_W-1:0] tx_word,
  input  logic             autoneg_en,
  input  logic             tx_disable,
  input  logic             loopback_en,
  output logic [1:0]       line_lvl,
  output logic             lb_bit
);

  localparam int FLP_IDX = SYM_W - 1;

  logic      ser_bit;
  logic      ser_clr;
  logic      enc_clr;
  line_lvl_t mlt_lvl;
  line_lvl_t line_sel;

  tx_serializer #(.SYM_W(SYM_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ser_clr),
    .load  (word_stb),
    .word  (tx_word),
    .bit_o (ser_bit)
  );

  nrzi_mlt3_enc u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (enc_clr),
    .bit_in  (ser_bit),
    .level_o (mlt_lvl)
  );

  tx_line_sel u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .dis       (tx_disable),
    .an        (autoneg_en),
    .lb        (loopback_en),
    .flp_in    (tx_word[FLP_IDX]),
    .ser_bit   (ser_bit),
    .mlt_lvl   (mlt_lvl),
    .line_o    (line_sel),
    .lb_bit_o  (lb_bit),
    .ser_clr_o (ser_clr),
    .enc_clr_o (enc_clr)
  );

  assign line_lvl = line_sel;

endmodule

// File: tb/mlt3_tx_path_bench.sv
module mlt3_tx_path_bench;

  logic       clk;
  logic       rst_n;
  logic       word_stb;
  logic [4:0] tx_word;
  logic       autoneg_en;
  logic       tx_disable;
  logic       loopback_en;
  logic [1:0] line_lvl;
  logic       lb_bit;

  int total;
  int bad;
  bit done;

  // bench reference state, built from the requirements
  logic [4:0] m_shift;
  int         m_phase;
  logic       m_flp;

  mlt3_tx_path u_mlt3_tx_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_stb    (word_stb),
    .tx_word     (tx_word),
    .autoneg_en  (autoneg_en),
    .tx_disable  (tx_disable),
    .loopback_en (loopback_en),
    .line_lvl    (line_lvl),
    .lb_bit      (lb_bit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] lvl_of(input int ph);
    case (ph % 4)
      1:       return 2'b01;
      3:       return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, advance model at posedge, compare at next negedge
  task automatic tick(input logic stb, input logic [4:0] w, input string tag);
    logic [1:0] exp_line;
    logic       exp_lb;
    word_stb = stb;
    tx_word  = w;
    @(posedge clk);
    if (tx_disable || autoneg_en || loopback_en) m_phase = 0;
    else if (m_shift[0]) m_phase = m_phase + 1;
    if (tx_disable) m_shift = '0;
    else if (stb) m_shift = w;
    else m_shift = m_shift >> 1;
    m_flp = w[4];
    @(negedge clk);
    if (tx_disable) exp_line = 2'b00;
    else if (autoneg_en) exp_line = m_flp ? 2'b01 : 2'b00;
    else if (loopback_en) exp_line = 2'b00;
    else exp_line = lvl_of(m_phase);
    exp_lb = loopback_en && !tx_disable && m_shift[0];
    chk({tag, " line"}, line_lvl, exp_line);
    chk({tag, " lb"}, {1'b0, lb_bit}, {1'b0, exp_lb});
  endtask

  task automatic clean_state();
    tx_disable = 1'b1;
    tick(1'b0, 5'd0, "R7 clean");
    tx_disable = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; word_stb = 1'b0; tx_word = '0;
    autoneg_en = 1'b0; tx_disable = 1'b0; loopback_en = 1'b0;
    m_shift = '0; m_phase = 0; m_flp = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset line", line_lvl, 2'b00);
    chk("R1 reset lb", {1'b0, lb_bit}, 2'b00);
    rst_n = 1'b1;
    tick(1'b0, 5'd0, "R1 first cycle");
  endtask

  task automatic t_all_ones();
    clean_state();
    tick(1'b1, 5'b11111, "R3 load");
    chk("R3 before first bit", line_lvl, 2'b00);
    tick(1'b0, 5'd0, "R3"); chk("R4 step1", line_lvl, 2'b01);
    tick(1'b0, 5'd0, "R3"); chk("R4 step2", line_lvl, 2'b00);
    tick(1'b0, 5'd0, "R3"); chk("R4 step3", line_lvl, 2'b11);
    tick(1'b0, 5'd0, "R3"); chk("R4 step4", line_lvl, 2'b00);
    tick(1'b0, 5'd0, "R3"); chk("R4 step5", line_lvl, 2'b01);
  endtask

  task automatic t_lsb_first();
    clean_state();
    tick(1'b1, 5'b00010, "R2 load");
    tick(1'b0, 5'd0, "R2"); chk("R2 bit0 zero", line_lvl, 2'b00);
    tick(1'b0, 5'd0, "R2"); chk("R2 bit1 one", line_lvl, 2'b01);
    for (int i = 0; i < 6; i++) tick(1'b0, 5'd0, "R5");
    chk("R5 idle hold", line_lvl, 2'b01);
  endtask

  task automatic t_disable();
    clean_state();
    tick(1'b1, 5'b11011, "R7 load");
    tick(1'b0, 5'd0, "R7");
    tick(1'b0, 5'd0, "R7");
    tx_disable = 1'b1;
    #1;
    chk("R7 same cycle quiet", line_lvl, 2'b00);
    tick(1'b0, 5'd0, "R7 held");
    tick(1'b1, 5'b11111, "R7 strobe ignored");
    tx_disable = 1'b0;
    tick(1'b0, 5'd0, "R7 after release");
    chk("R7 no leftover bits", line_lvl, 2'b00);
    tick(1'b1, 5'b00001, "R7 reload");
    tick(1'b0, 5'd0, "R7");
    chk("R7 restart at plus", line_lvl, 2'b01);
  endtask

  task automatic t_autoneg();
    clean_state();
    tick(1'b1, 5'b00001, "R6 prime");
    tick(1'b0, 5'd0, "R6 prime");
    autoneg_en = 1'b1;
    tick(1'b0, 5'b10000, "R6"); chk("R6 pulse high", line_lvl, 2'b01);
    tick(1'b0, 5'b00000, "R6"); chk("R6 pulse low", line_lvl, 2'b00);
    tick(1'b0, 5'b10000, "R6");
    tick(1'b0, 5'b10000, "R6"); chk("R6 pulse held", line_lvl, 2'b01);
    tx_disable = 1'b1;
    tick(1'b0, 5'b10000, "R9"); chk("R9 disable over autoneg", line_lvl, 2'b00);
    tx_disable = 1'b0;
    loopback_en = 1'b1;
    tick(1'b1, 5'b10001, "R9"); chk("R9 autoneg over loopback", line_lvl, 2'b01);
    tick(1'b0, 5'b00000, "R9");
    loopback_en = 1'b0;
    autoneg_en = 1'b0;
    tick(1'b0, 5'd0, "R6 exit");
    chk("R6 encoder held zero", line_lvl, 2'b00);
  endtask

  task automatic t_loopback();
    clean_state();
    loopback_en = 1'b1;
    tick(1'b1, 5'b10110, "R8 load");
    chk("R8 tap bit0", {1'b0, lb_bit}, 2'b00);
    tick(1'b0, 5'd0, "R8"); chk("R8 tap bit1", {1'b0, lb_bit}, 2'b01);
    tick(1'b0, 5'd0, "R8"); chk("R8 tap bit2", {1'b0, lb_bit}, 2'b01);
    tick(1'b0, 5'd0, "R8"); chk("R8 tap bit3", {1'b0, lb_bit}, 2'b00);
    tick(1'b0, 5'd0, "R8"); chk("R8 tap bit4", {1'b0, lb_bit}, 2'b01);
    chk("R8 line quiet", line_lvl, 2'b00);
    loopback_en = 1'b0;
    tick(1'b1, 5'b11111, "R8 off");
    chk("R8 tap off", {1'b0, lb_bit}, 2'b00);
  endtask

  task automatic t_stream();
    logic [4:0] lfsr;
    lfsr = 5'b10101;
    clean_state();
    for (int g = 0; g < 60; g++) begin
      tick(1'b1, lfsr, "R10");
      for (int b = 0; b < 4; b++) tick(1'b0, lfsr, "R10");
      lfsr = {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    end
    tick(1'b1, 5'b11111, "R2 mid reload");
    tick(1'b0, 5'd0, "R2");
    tick(1'b1, 5'b00000, "R2 replace");
    for (int b = 0; b < 6; b++) tick(1'b0, 5'd0, "R2 replaced");
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    do_reset();
    t_all_ones();
    t_lsb_first();
    t_disable();
    t_autoneg();
    t_loopback();
    t_stream();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R10: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule